// File: doc/BRIEF.md
# Line-Voltage Mismatch Fault Detector

This block watches one line-to-line voltage of a three-phase, two-level converter and decides whether one of the two legs that produce it has stopped following its switch commands. Each time a new sample arrives, it builds the voltage that the two legs ought to produce. That estimate is the difference of the two upper-switch commands multiplied by the sampled DC-link voltage. It then compares the estimate with the measured (or derived) line voltage.

A mismatch larger than a programmable tolerance marks the sample as erroneous. Dead time, driver delay and sensor lag all produce short mismatches on a healthy converter. To keep these from raising a fault, the block counts consecutive erroneous samples and declares a fault only once the run is longer than a programmable limit. Any clean sample restarts the count. The fault flag stays set until a clear input is pulsed, so a supervisor can reconfigure the converter at its own pace.

Three instances, one for each leg pair, feed a fault-location stage. Two of the instances can watch measured line voltages, and the third can watch the negated sum of those two.

Top module: `linev_mismatch_det`

## Requirements
- R1: The estimate is +Vdc when the first leg's upper command is 1 and the second's is 0. It is −Vdc for the opposite case, and 0 when both commands are equal.
- R2: On a sample strobe, the error flag is set if |line sample − estimate| is strictly greater than the threshold, and cleared otherwise. The flag is visible the cycle after the strobe and holds until the next strobe.
- R3: The run counter advances on each strobe whose sample is erroneous. It returns to zero on a strobe whose sample is within tolerance.
- R4: The fault flag rises on the strobe at which the run count becomes greater than the limit, so it rises on the (limit+1)-th consecutive erroneous sample. It is visible the following cycle.
- R5: Once set, the fault flag stays set through any later samples until clear is asserted. Clear zeroes the fault flag, the error flag and the counter, and it takes priority over a simultaneous strobe.
- R6: In cycles without a strobe, changes of the commands, voltages or threshold leave the error flag, the counter and the fault flag unchanged.
- R7: The run counter saturates at its all-ones value instead of wrapping. A limit equal to all-ones therefore never raises a fault.
- R8: After reset, the error flag, the fault flag and the counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clears the latched fault, error flag and counter |
| smp_stb | input | 1 | One-cycle strobe marking a valid sample |
| cmd_i | input | 1 | Upper-switch command of the first leg (1 = closed) |
| cmd_j | input | 1 | Upper-switch command of the second leg (1 = closed) |
| vdc | input | VW | DC-link voltage sample, signed |
| vline | input | VW | Line-to-line voltage sample, signed |
| thr | input | VW | Mismatch tolerance, unsigned |
| run_lim | input | CW | Persistence limit N |
| err_flag | output | 1 | Error flag of the latest sample |
| fault | output | 1 | Latched fault flag |

## Verification
The bench builds the block with 16-bit voltages and a 6-bit run counter. With that counter width, saturation is reached after 63 erroneous samples. The bench drives 80 erroneous samples at the all-ones limit, then lowers the limit by one. A saturating counter trips the fault on the next sample, while a wrapping counter would not. Small limits (0 and 3) make the exact rising sample of the fault and the restart after a single clean sample easy to observe. The threshold boundary is probed at exactly the tolerance and one step above it, with errors of both signs.

// File: rtl/lvm_pkg.sv
package lvm_pkg;

  typedef enum logic [1:0] {
    EST_ZERO = 2'd0,
    EST_POS  = 2'd1,
    EST_NEG  = 2'd2
  } est_sel_e;

  function automatic est_sel_e est_select(input logic up_i, input logic up_j);
    est_sel_e s;
    if (up_i == up_j)  s = EST_ZERO;
    else if (up_i)     s = EST_POS;
    else               s = EST_NEG;
    return s;
  endfunction

endpackage

// File: rtl/lvm_estimator.sv
module lvm_estimator
  import lvm_pkg::*;
#(
  parameter int VW = 16,
  localparam int EW = VW + 1
) (
  input  logic                 up_i,
  input  logic                 up_j,
  input  logic signed [VW-1:0] vdc,
  output logic signed [EW-1:0] vest,
  output est_sel_e             sel
);

  logic signed [EW-1:0] vdc_x;

  always_comb begin
    vdc_x = EW'(vdc);
    sel   = est_select(up_i, up_j);
    unique case (sel)
      EST_POS: vest = vdc_x;
      EST_NEG: vest = -vdc_x;
      default: vest = '0;
    endcase
  end

endmodule

// File: rtl/lvm_compare.sv
module lvm_compare #(
  parameter int VW = 16,
  localparam int EW = VW + 1,
  localparam int DW = VW + 2
) (
  input  logic signed [VW-1:0] vline,
  input  logic signed [EW-1:0] vest,
  input  logic        [VW-1:0] thr,
  output logic        [DW-1:0] mag,
  output logic                 over
);

  function automatic logic [DW-1:0] abs_diff(input logic signed [VW-1:0] a,
                                             input logic signed [EW-1:0] b);
    logic signed [DW-1:0] d;
    d = DW'(a) - DW'(b);
    return d[DW-1] ? DW'(-d) : DW'(d);
  endfunction

  always_comb begin
    mag  = abs_diff(vline, vest);
    over = mag > {2'b00, thr};
  end

endmodule

// File: rtl/lvm_persist.sv
module lvm_persist #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          stb,
  input  logic          over,
  input  logic [CW-1:0] lim,
  output logic          err_flag,
  output logic [CW-1:0] cnt,
  output logic          fault,
  output logic          trip
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_nx;

  always_comb begin
    if (!over)             cnt_nx = '0;
    else if (cnt == CMAX)  cnt_nx = CMAX;
    else                   cnt_nx = cnt + 1'b1;
    trip = stb && !clr && (cnt_nx > lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      cnt      <= '0;
      fault    <= 1'b0;
    end else if (clr) begin
      err_flag <= 1'b0;
      cnt      <= '0;
      fault    <= 1'b0;
    end else if (stb) begin
      err_flag <= over;
      cnt      <= cnt_nx;
      if (trip) fault <= 1'b1;
    end
  end

endmodule

// File: rtl/linev_mismatch_det.sv
module linev_mismatch_det
  import lvm_pkg::*;
#(
  parameter int VW = 16,
  parameter int CW = 8,
  localparam int EW = VW + 1,
  localparam int DW = VW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 smp_stb,
  input  logic                 cmd_i,
  input  logic                 cmd_j,
  input  logic signed [VW-1:0] vdc,
  input  logic signed [VW-1:0] vline,
  input  logic        [VW-1:0] thr,
  input  logic        [CW-1:0] run_lim,
  output logic                 err_flag,
  output logic                 fault
);

  logic signed [EW-1:0] vest;
  est_sel_e             est_sel;
  logic        [DW-1:0] err_mag;
  logic                 mis;
  logic        [CW-1:0] run_cnt;
  logic                 trip;

  lvm_estimator #(.VW(VW)) u_est (
    .up_i (cmd_i),
    .up_j (cmd_j),
    .vdc  (vdc),
    .vest (vest),
    .sel  (est_sel)
  );

  lvm_compare #(.VW(VW)) u_cmp (
    .vline (vline),
    .vest  (vest),
    .thr   (thr),
    .mag   (err_mag),
    .over  (mis)
  );

  lvm_persist #(.CW(CW)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .stb      (smp_stb),
    .over     (mis),
    .lim      (run_lim),
    .err_flag (err_flag),
    .cnt      (run_cnt),
    .fault    (fault),
    .trip     (trip)
  );

endmodule

// File: rtl/lvm_checker.sv
module lvm_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          smp_stb,
  input logic          mis,
  input logic [CW-1:0] run_lim,
  input logic [CW-1:0] run_cnt,
  input logic          err_flag,
  input logic          fault
);

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !clr) |=> fault); // R5

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!fault && !err_flag && run_cnt == '0)); // R5

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb && !clr) |=> ($stable(err_flag) && $stable(run_cnt) && $stable(fault))); // R6

  AST_RUN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !clr && !mis) |=> (run_cnt == '0 && !err_flag)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !clr && mis && run_cnt == CMAX) |=> run_cnt == CMAX); // R7

  AST_TRIP_ABOVE_LIM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (run_cnt > $past(run_lim))); // R4

endmodule

bind linev_mismatch_det lvm_checker #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .smp_stb  (smp_stb),
  .mis      (mis),
  .run_lim  (run_lim),
  .run_cnt  (run_cnt),
  .err_flag (err_flag),
  .fault    (fault)
);

// File: tb/tb_linev_mismatch_det.sv
`timescale 1ns/1ps
module tb_linev_mismatch_det;

  localparam int VW = 16;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic smp_stb = 1'b0;
  logic cmd_i = 1'b0;
  logic cmd_j = 1'b0;
  logic signed [VW-1:0] vdc = '0;
  logic signed [VW-1:0] vline = '0;
  logic [VW-1:0] thr = '0;
  logic [CW-1:0] run_lim = '0;
  logic err_flag;
  logic fault;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  linev_mismatch_det #(.VW(VW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .smp_stb(smp_stb),
    .cmd_i(cmd_i), .cmd_j(cmd_j), .vdc(vdc), .vline(vline),
    .thr(thr), .run_lim(run_lim), .err_flag(err_flag), .fault(fault)
  );

  function automatic bit ref_err(int si, int sj, int vd, int vl, int th);
    int d;
    d = vl - (si - sj) * vd;
    if (d < 0) d = -d;
    return d > th;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sample(int si, int sj, int vd, int vl);
    @(negedge clk);
    cmd_i = si[0]; cmd_j = sj[0];
    vdc = VW'(vd); vline = VW'(vl);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 err after reset", int'(err_flag), 0);
    check("R8 fault after reset", int'(fault), 0);
  endtask

  task automatic t_estimate();
    thr = 16'd10; run_lim = 6'd40;
    do_clear();
    for (int si = 0; si < 2; si++) begin
      for (int sj = 0; sj < 2; sj++) begin
        int est;
        est = (si - sj) * 300;
        sample(si, sj, 300, est);
        check("R1 exact estimate", int'(err_flag), int'(ref_err(si, sj, 300, est, 10)));
        sample(si, sj, 300, est + 40);
        check("R1 offset estimate", int'(err_flag), 1);
      end
    end
  endtask

  task automatic t_threshold();
    thr = 16'd10; run_lim = 6'd40;
    do_clear();
    sample(1, 0, 300, 310);
    check("R2 error equal to threshold", int'(err_flag), 0);
    sample(1, 0, 300, 311);
    check("R2 error above threshold", int'(err_flag), 1);
    sample(0, 1, 300, -311);
    check("R2 negative error above threshold", int'(err_flag), 1);
    sample(0, 1, 300, -290);
    check("R2 positive error at threshold", int'(err_flag), 0);
    repeat (3) @(negedge clk);
    check("R2 flag holds between strobes", int'(err_flag), 0);
  endtask

  task automatic t_persist();
    thr = 16'd10; run_lim = 6'd3;
    do_clear();
    for (int k = 0; k < 3; k++) sample(1, 1, 500, 200);
    check("R4 no fault at limit", int'(fault), 0);
    sample(1, 1, 500, 200);
    check("R4 fault above limit", int'(fault), 1);
  endtask

  task automatic t_restart();
    thr = 16'd10; run_lim = 6'd3;
    do_clear();
    for (int k = 0; k < 3; k++) sample(0, 1, 500, 0);
    sample(0, 1, 500, -500);
    check("R3 clean sample clears flag", int'(err_flag), 0);
    for (int k = 0; k < 3; k++) sample(0, 1, 500, 0);
    check("R3 count restarted", int'(fault), 0);
    sample(0, 1, 500, 0);
    check("R3 fault after fresh run", int'(fault), 1);
  endtask

  task automatic t_latch();
    sample(0, 0, 500, 0);
    sample(1, 0, 500, 500);
    check("R5 fault held on clean samples", int'(fault), 1);
    do_clear();
    check("R5 clear drops fault", int'(fault), 0);
    run_lim = 6'd0;
    @(negedge clk);
    clr = 1'b1; smp_stb = 1'b1;
    cmd_i = 1'b1; cmd_j = 1'b0; vdc = 16'sd500; vline = 16'sd0;
    @(negedge clk);
    clr = 1'b0; smp_stb = 1'b0;
    check("R5 clear beats strobe fault", int'(fault), 0);
    check("R5 clear beats strobe err", int'(err_flag), 0);
  endtask

  task automatic t_idle();
    thr = 16'd10; run_lim = 6'd0;
    do_clear();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      cmd_i = k[0]; cmd_j = ~k[0];
      vdc = 16'sd1000; vline = VW'(-3000 + k);
      thr = 16'd0;
    end
    @(negedge clk);
    check("R6 idle err unchanged", int'(err_flag), 0);
    check("R6 idle fault unchanged", int'(fault), 0);
    thr = 16'd10;
    sample(1, 1, 100, 0);
    check("R6 no hidden count", int'(fault), 0);
  endtask

  task automatic t_saturate();
    thr = 16'd10; run_lim = 6'd63;
    do_clear();
    for (int k = 0; k < 80; k++) sample(1, 0, 200, 0);
    check("R7 all-ones limit never trips", int'(fault), 0);
    run_lim = 6'd62;
    sample(1, 0, 200, 0);
    check("R7 saturated count trips", int'(fault), 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_estimate();
    t_threshold();
    t_persist();
    t_restart();
    t_latch();
    t_idle();
    t_saturate();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule